// File: doc/BRIEF.md
# Paired 8-bit Cascadable Timer

This block holds two 8-bit up-counters that share a small register window on a synchronous register bus. Each channel counts either a tick from a shared prescaler, which divides the system clock by one of seven ratios, or an event taken from the other channel. Each channel has two compare values. A compare value matches when the counter steps away from it. The counter can be cleared on either match. Every channel raises three single-cycle interrupt pulses: compare A, compare B and overflow.

Bit 0 of the address picks the channel for a byte access. A halfword access reaches both channels at once, so software can read or load the pair as one 16-bit quantity. Channel 0 can count the overflows of channel 1, and channel 1 can count the compare-A matches of channel 0. When channel 0 counts channel 1 overflows and channel 1 runs from the prescaler, the pair forms a 16-bit counter. Its compare logic is then silenced and only the combined wrap is reported.

Top module: `twin_tick_timer`

## Requirements
- R1: Byte offsets decode as: control 0, status 2, compare A 4, compare B 6, counter 8, clock select 10. Address bit 0 picks the channel (0 or 1), and byte reads return the register in bits 7:0 with bits 15:8 zero.
- R2: A halfword access at offset 4 to 11 reads or writes both channels together. Channel 0 is in bits 15:8 and channel 1 is in bits 7:0.
- R3: A halfword access at offsets 0 to 3 reads 0xFFFF and a write there changes no register.
- R4: Offsets 12 to 15 read as zero for byte and halfword accesses.
- R5: After reset the compare registers hold 0xFF and every other register holds 0x00, except channel 1 status, which holds 0x10. Channel 1 status bit 4 always reads 1, whatever value is written.
- R6: In the clock select register, bits 6:5 always read 0. Bits 4:3 pick the source: 01 is the prescaler, 11 is the cross-channel event, 00 and 10 stop the counter. Bits 2:0 select a period of 1, 2, 8, 32, 64, 1024 or 8192 clocks for codes 0 to 6, and code 7 stops the counter.
- R7: A compare match occurs on a count step taken while the counter equals that compare value. Control bits 4:3 select the clear: 01 clears on A, 10 clears on B, and any other value never clears, so the counter steps on to value+1.
- R8: Control bit 0 enables the compare-A pulse, bit 1 the compare-B pulse and bit 2 the overflow pulse. Each pulse is high for the one cycle after the clock edge on which its event happens.
- R9: A count step from 0xFF wraps the counter to 0x00 and is an overflow event.
- R10: A channel 0 in event mode steps on the same clock edge as each channel 1 overflow.
- R11: A channel 1 in event mode steps one clock edge after each channel 0 compare-A match.
- R12: The pair is in 16-bit mode when channel 0 is in event mode with clear select 00 and channel 1 uses the prescaler. In this mode, compare matches of both channels neither clear nor pulse. A wrap from 0xFFFF to 0x0000 zeroes both counters and pulses the channel 0 overflow when that pulse is enabled.
- R13: A counter write takes priority over a count step on the same edge. A halfword counter write loads both channels on that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| irq_cmp_a | output | 2 | Compare-A pulse, one bit per channel |
| irq_cmp_b | output | 2 | Compare-B pulse, one bit per channel |
| irq_ovf | output | 2 | Overflow pulse, one bit per channel |

## Verification
The bench builds the block with the default prescaler width of 13 bits, so all seven divide ratios exist in hardware. Divide-by-one gives cycle-exact timing of matches, clears, wraps and the one-cycle cascade lag. Divide-by-eight is measured over a 64-cycle window, which holds exactly eight ticks whatever the prescaler phase. In 16-bit mode the bench starts the pair just below the wrap and then runs a full channel-1 revolution, so the carry into channel 0 is seen within a few hundred cycles.

// File: rtl/twin_tick_pkg.sv
`timescale 1ns/1ps
package twin_tick_pkg;
   localparam int BYTE_W = 8;
   localparam int CH_N   = 2;
   localparam int REG_N  = 6;

   // register index taken from address bits 3:1
   localparam logic [2:0] RG_CTRL = 3'd0;
   localparam logic [2:0] RG_STAT = 3'd1;
   localparam logic [2:0] RG_CMPA = 3'd2;
   localparam logic [2:0] RG_CMPB = 3'd3;
   localparam logic [2:0] RG_CNT  = 3'd4;
   localparam logic [2:0] RG_CLK  = 3'd5;

   typedef enum logic [1:0] {SRC_OFF = 2'd0, SRC_INT = 2'd1, SRC_OFF2 = 2'd2, SRC_EVT = 2'd3} src_e;
   typedef enum logic [1:0] {CLR_NONE = 2'd0, CLR_A = 2'd1, CLR_B = 2'd2, CLR_NONE2 = 2'd3} clr_e;

   localparam logic [BYTE_W-1:0] CLK_RSVD = 8'h60;
   localparam int MAX_SHIFT = 13;

   // log2 of the prescaler period for each divider code; code 7 is off
   function automatic int div_shift(input int code);
      case (code)
         0: return 0;
         1: return 1;
         2: return 3;
         3: return 5;
         4: return 6;
         5: return 10;
         6: return 13;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/twin_tick_prescale.sv
`timescale 1ns/1ps
module twin_tick_prescale
   import twin_tick_pkg::*;
#(
   parameter int PRESC_W = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [7:0] tick_o
);
   if (PRESC_W < MAX_SHIFT) begin : g_bad_width
      $error("twin_tick_prescale: PRESC_W must cover the largest divider");
   end

   logic [PRESC_W-1:0] pcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
   end

   for (genvar k = 0; k < 8; k++) begin : g_tick
      localparam int SH = div_shift(k);
      if (k == 7) begin : g_off
         assign tick_o[k] = 1'b0;
      end else if (SH == 0) begin : g_every
         assign tick_o[k] = 1'b1;
      end else begin : g_div
         assign tick_o[k] = &pcnt_q[SH-1:0];
      end
   end
endmodule

// File: rtl/twin_tick_channel.sv
`timescale 1ns/1ps
module twin_tick_channel
   import twin_tick_pkg::*;
#(
   parameter int           W          = 8,
   parameter int           NREG       = 6,
   parameter logic [W-1:0] STAT_INIT  = '0,
   parameter logic [W-1:0] STAT_FORCE = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREG-1:0]         we_i,
   input  logic [W-1:0]            wdata_i,
   input  logic [7:0]              tick_i,
   input  logic                    evt_i,
   input  logic                    wide_i,
   output logic [NREG-1:0][W-1:0]  regs_o,
   output logic                    hit_a_o,
   output logic                    ovf_o,
   output logic                    irq_a_o,
   output logic                    irq_b_o,
   output logic                    irq_o_o
);
   if (W < 5) begin : g_bad_w
      $error("twin_tick_channel: W too small for control fields");
   end

   logic [W-1:0] ctrl_q, stat_q, cmpa_q, cmpb_q, cnt_q, clk_q;
   logic         step, hit_a, hit_b, ovf, clr;
   src_e         src;
   clr_e         csel;

   assign src  = src_e'(clk_q[4:3]);
   assign csel = clr_e'(ctrl_q[4:3]);

   always_comb begin
      step = 1'b0;
      if (!we_i[RG_CNT]) begin
         if (src == SRC_INT)      step = tick_i[clk_q[2:0]];
         else if (src == SRC_EVT) step = evt_i;
      end
      hit_a = step && !wide_i && (cnt_q == cmpa_q);
      hit_b = step && !wide_i && (cnt_q == cmpb_q);
      ovf   = step && (&cnt_q);
      clr   = ((csel == CLR_A) && hit_a) || ((csel == CLR_B) && hit_b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         stat_q  <= STAT_INIT;
         cmpa_q  <= '1;
         cmpb_q  <= '1;
         cnt_q   <= '0;
         clk_q   <= '0;
         irq_a_o <= 1'b0;
         irq_b_o <= 1'b0;
         irq_o_o <= 1'b0;
      end else begin
         if (we_i[RG_CTRL]) ctrl_q <= wdata_i;
         if (we_i[RG_STAT]) stat_q <= wdata_i | STAT_FORCE;
         if (we_i[RG_CMPA]) cmpa_q <= wdata_i;
         if (we_i[RG_CMPB]) cmpb_q <= wdata_i;
         if (we_i[RG_CLK])  clk_q  <= wdata_i & ~CLK_RSVD[W-1:0];
         if (we_i[RG_CNT])  cnt_q  <= wdata_i;
         else if (clr)      cnt_q  <= '0;
         else if (step)     cnt_q  <= cnt_q + 1'b1;
         irq_a_o <= hit_a & ctrl_q[0];
         irq_b_o <= hit_b & ctrl_q[1];
         irq_o_o <= ovf   & ctrl_q[2];
      end
   end

   always_comb begin
      regs_o         = '0;
      regs_o[RG_CTRL] = ctrl_q;
      regs_o[RG_STAT] = stat_q;
      regs_o[RG_CMPA] = cmpa_q;
      regs_o[RG_CMPB] = cmpb_q;
      regs_o[RG_CNT]  = cnt_q;
      regs_o[RG_CLK]  = clk_q;
   end

   assign hit_a_o = hit_a;
   assign ovf_o   = ovf;

   // R7: clearing on compare A returns the counter to zero
   p_clear_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (csel == CLR_A && hit_a) |=> (cnt_q == '0));
   // R9: an overflow step leaves the counter at zero
   p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == '0));
   // R8: overflow pulses never last two cycles
   p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o_o |=> !irq_o_o);
   // R13: a counter write lands regardless of counting
   p_load_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[RG_CNT] |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/twin_tick_timer.sv
`timescale 1ns/1ps
module twin_tick_timer
   import twin_tick_pkg::*;
#(
   parameter int PRESC_W = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_word,
   input  logic [3:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic [1:0]  irq_cmp_a,
   output logic [1:0]  irq_cmp_b,
   output logic [1:0]  irq_ovf
);
   if (CH_N != 2) begin : g_bad_ch
      $error("twin_tick_timer: halfword packing needs exactly two channels");
   end

   logic [7:0]                    tick;
   logic [2:0]                    sel_idx;
   logic                          sel_ok, word_ok, wide, casc_q;
   logic [REG_N-1:0][BYTE_W-1:0]  regs   [CH_N];
   logic                          hit_a  [CH_N];
   logic                          ovf_ev [CH_N];
   logic                          evt    [CH_N];

   assign sel_idx = bus_addr[3:1];
   assign sel_ok  = (sel_idx < 3'(REG_N));
   assign word_ok = !bus_word || (bus_addr[3:2] != 2'b00);

   twin_tick_prescale #(.PRESC_W(PRESC_W)) i_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   // channel 1 sees channel 0 compare-A through a register; channel 0
   // sees channel 1 overflow directly so the 16-bit carry is exact
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) casc_q <= 1'b0;
      else        casc_q <= hit_a[0];
   end
   assign evt[0] = ovf_ev[1];
   assign evt[1] = casc_q;

   assign wide = (regs[0][RG_CLK][4:3] == SRC_EVT) &&
                 (regs[1][RG_CLK][4:3] == SRC_INT) &&
                 (regs[0][RG_CTRL][4:3] == CLR_NONE);

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      logic [REG_N-1:0]  we_c;
      logic [BYTE_W-1:0] wd_c;

      always_comb begin
         for (int r = 0; r < REG_N; r++) begin
            we_c[r] = bus_wr && word_ok && sel_ok && (sel_idx == 3'(r)) &&
                      (bus_word || (bus_addr[0] == 1'(c)));
         end
      end

      if (c == 0) begin : g_hi
         assign wd_c = bus_word ? bus_wdata[15:8] : bus_wdata[7:0];
      end else begin : g_lo
         assign wd_c = bus_wdata[7:0];
      end

      twin_tick_channel #(
         .W          (BYTE_W),
         .NREG       (REG_N),
         .STAT_INIT  ((c == 1) ? 8'h10 : 8'h00),
         .STAT_FORCE ((c == 1) ? 8'h10 : 8'h00)
      ) i_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (we_c),
         .wdata_i (wd_c),
         .tick_i  (tick),
         .evt_i   (evt[c]),
         .wide_i  (wide),
         .regs_o  (regs[c]),
         .hit_a_o (hit_a[c]),
         .ovf_o   (ovf_ev[c]),
         .irq_a_o (irq_cmp_a[c]),
         .irq_b_o (irq_cmp_b[c]),
         .irq_o_o (irq_ovf[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (!word_ok) begin
         bus_rdata = '1;
      end else if (sel_ok) begin
         if (bus_word) bus_rdata = {regs[0][sel_idx], regs[1][sel_idx]};
         else          bus_rdata = {8'h00, regs[bus_addr[0]][sel_idx]};
      end
   end

   // R3: a halfword read below offset 4 returns all ones
   p_bad_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_word && bus_addr < 4'd4) |-> (bus_rdata == 16'hFFFF));
   // R4: the unused top of the window reads zero
   p_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= 4'd12) |-> (bus_rdata == 16'h0000));
   // R5: channel 1 status bit 4 is seen set on every byte read
   p_stat_bit4_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_word && bus_addr == 4'd3) |-> bus_rdata[4]);
   // R12: a combined wrap leaves both halves at zero
   p_wide_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wide && ovf_ev[0]) |=> (regs[0][RG_CNT] == 8'h00 && regs[1][RG_CNT] == 8'h00));
endmodule

// File: tb/test_twin_tick_timer.sv
`timescale 1ns/1ps
module test_twin_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_word = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  irq_cmp_a, irq_cmp_b, irq_ovf;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   twin_tick_timer i_twin_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_cmp_a (irq_cmp_a),
      .irq_cmp_b (irq_cmp_b),
      .irq_ovf   (irq_ovf)
   );

   // {req[3:0], write, word, addr[3:0], data[15:0]}; data is expected value on reads
   localparam int NV = 23;
   localparam logic [25:0] VEC [NV] = '{
      {4'd1,  1'b1, 1'b0, 4'd4,  16'h0012},   // R1 byte write ch0 compare A
      {4'd2,  1'b0, 1'b1, 4'd4,  16'h12FF},   // R2 halfword read, ch0 high
      {4'd1,  1'b1, 1'b0, 4'd5,  16'h0034},   // R1 byte write ch1 compare A
      {4'd2,  1'b0, 1'b1, 4'd4,  16'h1234},   // R2
      {4'd2,  1'b1, 1'b1, 4'd6,  16'hABCD},   // R2 halfword write compare B
      {4'd2,  1'b0, 1'b0, 4'd6,  16'h00AB},   // R2 ch0 took upper byte
      {4'd2,  1'b0, 1'b0, 4'd7,  16'h00CD},   // R2 ch1 took lower byte
      {4'd5,  1'b1, 1'b0, 4'd3,  16'h0000},   // R5 try to clear ch1 status
      {4'd5,  1'b0, 1'b0, 4'd3,  16'h0010},   // R5 bit 4 stays
      {4'd1,  1'b1, 1'b0, 4'd2,  16'h005A},   // R1 ch0 status
      {4'd1,  1'b0, 1'b0, 4'd2,  16'h005A},   // R1
      {4'd3,  1'b1, 1'b1, 4'd0,  16'hFFFF},   // R3 illegal halfword write
      {4'd3,  1'b0, 1'b0, 4'd0,  16'h0000},   // R3 ch0 control untouched
      {4'd3,  1'b0, 1'b0, 4'd1,  16'h0000},   // R3 ch1 control untouched
      {4'd3,  1'b0, 1'b1, 4'd2,  16'hFFFF},   // R3 illegal halfword read
      {4'd4,  1'b0, 1'b0, 4'd12, 16'h0000},   // R4
      {4'd4,  1'b0, 1'b1, 4'd14, 16'h0000},   // R4
      {4'd6,  1'b1, 1'b0, 4'd10, 16'h00E7},   // R6 reserved bits written
      {4'd6,  1'b0, 1'b0, 4'd10, 16'h0087},   // R6 reserved bits read zero
      {4'd6,  1'b1, 1'b0, 4'd10, 16'h0000},   // R6 stop again
      {4'd13, 1'b1, 1'b1, 4'd8,  16'hBEEF},   // R13 halfword counter load
      {4'd13, 1'b0, 1'b1, 4'd8,  16'hBEEF},   // R13
      {4'd1,  1'b0, 1'b0, 4'd9,  16'h00EF}    // R1 ch1 counter byte
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // call with time just after a rising edge; returns 1ns after the write edge
   task automatic bus_write(input logic [3:0] a, input logic [15:0] d, input logic w);
      bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, input logic w, output logic [15:0] d);
      bus_addr = a; bus_word = w; bus_wr = 1'b0;
      #1;
      d = bus_rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired before the run ended");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step(1);

      // reset state, R5
      bus_read(4'd4, 1'b1, rd);  check("R5 compare A reset", rd, 16'hFFFF);
      bus_read(4'd6, 1'b1, rd);  check("R5 compare B reset", rd, 16'hFFFF);
      bus_read(4'd3, 1'b0, rd);  check("R5 ch1 status reset", rd, 16'h0010);
      bus_read(4'd2, 1'b0, rd);  check("R5 ch0 status reset", rd, 16'h0000);
      bus_read(4'd8, 1'b1, rd);  check("R5 counters reset", rd, 16'h0000);
      bus_read(4'd10, 1'b1, rd); check("R5 clock select reset", rd, 16'h0000);
      check("R8 no pulse after reset", {10'd0, irq_cmp_a, irq_cmp_b, irq_ovf}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][21]) begin
            bus_write(VEC[i][19:16], VEC[i][15:0], VEC[i][20]);
         end else begin
            bus_read(VEC[i][19:16], VEC[i][20], rd);
            checks++;
            if (rd !== VEC[i][15:0]) begin
               fails++;
               $display("FAIL vector %0d req R%0d actual=%h expected=%h",
                        i, VEC[i][25:22], rd, VEC[i][15:0]);
            end
         end
      end

      // R7 R8: clear on compare A with pulse
      bus_write(4'd10, 16'h0000, 1'b1);
      bus_write(4'd0, 16'h0009, 1'b0);
      bus_write(4'd4, 16'h0003, 1'b0);
      bus_write(4'd8, 16'h0000, 1'b0);
      bus_write(4'd10, 16'h0008, 1'b0);
      step(3);
      bus_read(4'd8, 1'b0, rd); check("R7 count reaches compare", rd, 16'h0003);
      check("R8 no pulse before match", {15'd0, irq_cmp_a[0]}, 16'h0000);
      step(1);
      bus_read(4'd8, 1'b0, rd); check("R7 clear on compare A", rd, 16'h0000);
      check("R8 compare A pulse", {15'd0, irq_cmp_a[0]}, 16'h0001);
      step(1);
      bus_read(4'd8, 1'b0, rd); check("R7 count resumes", rd, 16'h0001);
      check("R8 pulse lasts one cycle", {15'd0, irq_cmp_a[0]}, 16'h0000);

      // R7 R8: clear on compare B, compare A passed through
      bus_write(4'd10, 16'h0000, 1'b0);
      bus_write(4'd0, 16'h0012, 1'b0);
      bus_write(4'd6, 16'h0005, 1'b0);
      bus_write(4'd8, 16'h0000, 1'b0);
      bus_write(4'd10, 16'h0008, 1'b0);
      step(4);
      bus_read(4'd8, 1'b0, rd); check("R7 compare A does not clear", rd, 16'h0004);
      step(1);
      bus_read(4'd8, 1'b0, rd); check("R7 count at compare B", rd, 16'h0005);
      step(1);
      bus_read(4'd8, 1'b0, rd); check("R7 clear on compare B", rd, 16'h0000);
      check("R8 compare B pulse", {14'd0, irq_cmp_b[0], irq_cmp_a[0]}, 16'h0002);

      // R9 R8: channel 1 overflow
      bus_write(4'd10, 16'h0000, 1'b1);
      bus_write(4'd1, 16'h0004, 1'b0);
      bus_write(4'd9, 16'h00FD, 1'b0);
      bus_write(4'd11, 16'h0008, 1'b0);
      step(2);
      bus_read(4'd9, 1'b0, rd); check("R9 ch1 at top", rd, 16'h00FF);
      step(1);
      bus_read(4'd9, 1'b0, rd); check("R9 ch1 wraps", rd, 16'h0000);
      check("R9 overflow pulse", {15'd0, irq_ovf[1]}, 16'h0001);
      step(1);
      check("R8 overflow pulse ends", {15'd0, irq_ovf[1]}, 16'h0000);

      // R11: channel 1 counts channel 0 compare-A matches, one edge late
      bus_write(4'd10, 16'h0000, 1'b1);
      bus_write(4'd0, 16'h0008, 1'b0);
      bus_write(4'd4, 16'h0001, 1'b0);
      bus_write(4'd8, 16'h0000, 1'b1);
      bus_write(4'd10, 16'h0818, 1'b1);
      step(2);
      bus_read(4'd8, 1'b1, rd); check("R11 match seen, ch1 not yet", rd, 16'h0000);
      step(1);
      bus_read(4'd8, 1'b1, rd); check("R11 ch1 steps one edge later", rd, 16'h0101);
      step(7);
      bus_read(4'd8, 1'b1, rd); check("R11 four matches counted", rd, 16'h0004);

      // R12 R10: 16-bit mode
      bus_write(4'd10, 16'h0000, 1'b1);
      bus_write(4'd0, 16'h0004, 1'b0);
      bus_write(4'd1, 16'h000D, 1'b0);
      bus_write(4'd5, 16'h0005, 1'b0);
      bus_write(4'd8, 16'hFFFE, 1'b1);
      bus_write(4'd10, 16'h1808, 1'b1);
      step(1);
      bus_read(4'd8, 1'b1, rd); check("R12 combined top", rd, 16'hFFFF);
      step(1);
      bus_read(4'd8, 1'b1, rd); check("R12 combined wrap", rd, 16'h0000);
      check("R12 ch0 overflow pulse", {15'd0, irq_ovf[0]}, 16'h0001);
      step(6);
      bus_read(4'd8, 1'b1, rd); check("R12 compare ignored, no clear", rd, 16'h0006);
      check("R12 compare ignored, no pulse", {15'd0, irq_cmp_a[1]}, 16'h0000);
      step(250);
      bus_read(4'd8, 1'b1, rd); check("R10 carry into ch0", rd, 16'h0100);

      // R6: divide by 8, divider off, stopped source
      bus_write(4'd10, 16'h0000, 1'b1);
      bus_write(4'd0, 16'h0000, 1'b0);
      bus_write(4'd8, 16'h0000, 1'b0);
      bus_write(4'd10, 16'h000A, 1'b0);
      step(64);
      bus_read(4'd8, 1'b0, rd); check("R6 divide by 8", rd, 16'h0008);
      bus_write(4'd10, 16'h0000, 1'b0);
      bus_write(4'd8, 16'h0040, 1'b0);
      bus_write(4'd10, 16'h000F, 1'b0);
      step(20);
      bus_read(4'd8, 1'b0, rd); check("R6 divider code 7 stops", rd, 16'h0040);
      bus_write(4'd10, 16'h0010, 1'b0);
      step(20);
      bus_read(4'd8, 1'b0, rd); check("R6 source 10 stops", rd, 16'h0040);

      // R13: write wins over a running count
      bus_write(4'd10, 16'h0008, 1'b0);
      step(3);
      bus_write(4'd8, 16'h0080, 1'b0);
      bus_read(4'd8, 1'b0, rd); check("R13 load beats step", rd, 16'h0080);
      step(1);
      bus_read(4'd8, 1'b0, rd); check("R13 count after load", rd, 16'h0081);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule